// File: doc/BRIEF.md
# Value-Based Register Rename with Operand Capture

This block renames destination registers onto reorder buffer slots and holds each in-flight result inside its slot. No separate pool of physical registers exists: the slot index handed out at decode is the tag. A per-register mapping table records which in-flight slot will produce the next value of each architectural register. It also records whether that slot has already received its result.

At decode the block allocates the next slot in program order, and for each of two source registers it returns either a ready value or the tag of the slot still being waited on. A ready value comes from the slot's stored result, from a result arriving on the writeback port in the same cycle, or from the architectural register file when no writer is in flight. Writeback deposits a result into its slot. The oldest slot retires as soon as it holds its result. Retirement copies the value into the architectural register file and drops the mapping unless a younger writer of the same register has already replaced it. Issue selection and execution are outside the block.

Top module: `vr_rename_top`

## Requirements
- R1: After reset no slot is in flight: `dec_ready` is 1, `cmt_valid` is 0, and every source reads as not pending with value 0.
- R2: Slot tags are handed out in allocation order, starting at 0 after reset and wrapping from ROB_DEPTH-1 to 0. `dec_tag` shows the tag the next accepted decode receives.
- R3: `dec_ready` is 0 exactly when ROB_DEPTH slots are in flight, and a `dec_valid` presented while it is 0 allocates nothing and changes no mapping.
- R4: A source whose register has an in-flight writer without a result, and with no matching writeback this cycle, reads `srcN_pend`=1 with `srcN_tag` equal to the youngest such writer's slot.
- R5: A source whose register maps to an in-flight slot that already holds its result reads as not pending with that stored result.
- R6: A source whose register has no in-flight writer reads as not pending with the architectural register file value.
- R7: A writeback whose tag equals the slot a source would wait on is forwarded in the same cycle, so the source reads as not pending with the writeback value.
- R8: The oldest in-flight slot retires in the cycle in which it holds its result. `cmt_valid` is then 1 with its tag, destination register, write flag and value, at most one slot retires per cycle, and slots retire in allocation order.
- R9: A retiring slot with its write flag set updates the architectural register file. A slot decoded with `dec_wen`=0 leaves the architectural register file and the mapping table unchanged.
- R10: Retirement removes a register's mapping only while that mapping still names the retiring slot. A younger writer of the same register keeps its mapping.
- R11: When a decode writing register r is accepted in the same cycle as the retirement of r's current writer, the new mapping is kept.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| dec_valid | input | 1 | Decode presents an instruction |
| dec_ready | output | 1 | A slot is free for allocation |
| dec_rd | input | AREG_W | Destination architectural register |
| dec_wen | input | 1 | Instruction writes `dec_rd` |
| dec_rs0 | input | AREG_W | First source register |
| dec_rs1 | input | AREG_W | Second source register |
| dec_tag | output | TAG_W | Slot tag the accepted instruction receives |
| src0_pend | output | 1 | First source waits on a slot |
| src0_tag | output | TAG_W | Slot the first source waits on |
| src0_value | output | DATA_W | First source value when not pending |
| src1_pend | output | 1 | Second source waits on a slot |
| src1_tag | output | TAG_W | Slot the second source waits on |
| src1_value | output | DATA_W | Second source value when not pending |
| wb_valid | input | 1 | A result is delivered |
| wb_tag | input | TAG_W | Slot receiving the result |
| wb_value | input | DATA_W | Result value |
| cmt_valid | output | 1 | The oldest slot retires this cycle |
| cmt_tag | output | TAG_W | Tag of the retiring slot |
| cmt_areg | output | AREG_W | Destination register of the retiring slot |
| cmt_wen | output | 1 | Retiring slot writes its register |
| cmt_value | output | DATA_W | Value of the retiring slot |

## Verification
A mapping table entry that names the wrong slot, or that keeps a stale pending bit, appears in the same cycle on the next decode reading that register. The source then shows the wrong tag, a wrong pending flag, or a value from the wrong slot. A retirement that skips the architectural file write, or that drops a younger writer's mapping, shows up on the first later read of that register as a wrong file value or a missing pending tag. Slot order and occupancy faults show at once on `dec_tag`, `dec_ready` and the retirement outputs.

// File: rtl/vr_pkg.sv
// Package: shared defaults and the operand source kind for the value-based
// rename block. Assumes the importing modules size their own arrays.
package vr_pkg;
    localparam int unsigned VR_AREGS     = 8;
    localparam int unsigned VR_DATA_W    = 16;
    localparam int unsigned VR_ROB_DEPTH = 8;

    typedef enum logic [1:0] {
        SRC_ARF  = 2'd0,
        SRC_SLOT = 2'd1,
        SRC_FWD  = 2'd2,
        SRC_WAIT = 2'd3
    } src_kind_e;
endpackage

// File: rtl/vr_rename_table.sv
// Mapping table: per architectural register a valid bit, a pending bit and
// the slot tag of its youngest in-flight writer. Assumes an allocation and a
// retirement-side clear may target the same register in one cycle; the
// allocation wins. Two combinational lookup ports.
module vr_rename_table #(
    parameter int unsigned NUM_AREG = 8,
    parameter int unsigned TAG_W    = 3,
    localparam int unsigned AREG_W  = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [AREG_W-1:0] alloc_areg,
    input  logic [TAG_W-1:0]  alloc_tag,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic              clr_en,
    input  logic [AREG_W-1:0] clr_areg,
    input  logic [TAG_W-1:0]  clr_tag,
    input  logic [AREG_W-1:0] rd_areg  [2],
    output logic              rd_valid [2],
    output logic              rd_pend  [2],
    output logic [TAG_W-1:0]  rd_tag   [2]
);
    logic             valid_q [NUM_AREG];
    logic             pend_q  [NUM_AREG];
    logic [TAG_W-1:0] tag_q   [NUM_AREG];

    // Update mappings: allocate, clear on retirement if still owned, drop pending on writeback.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_AREG; i++) begin
            if (!rst_n) begin
                valid_q[i] <= 1'b0;
                pend_q[i]  <= 1'b0;
                tag_q[i]   <= '0;
            end else if (alloc_en && alloc_areg == AREG_W'(i)) begin
                valid_q[i] <= 1'b1;
                pend_q[i]  <= 1'b1;
                tag_q[i]   <= alloc_tag;
            end else begin
                if (clr_en && clr_areg == AREG_W'(i) && valid_q[i] && tag_q[i] == clr_tag)
                    valid_q[i] <= 1'b0;
                if (wb_en && valid_q[i] && tag_q[i] == wb_tag)
                    pend_q[i] <= 1'b0;
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_lookup
        // Read one mapping for a source register.
        always_comb begin
            rd_valid[p] = valid_q[rd_areg[p]];
            rd_pend[p]  = pend_q[rd_areg[p]];
            rd_tag[p]   = tag_q[rd_areg[p]];
        end
    end
endmodule

// File: rtl/vr_rob.sv
// Reorder buffer slots holding destination register, write flag, result and
// a done bit. Circular allocation at the tail, retirement at the head.
// Assumes writebacks only target allocated slots that have no result yet.
module vr_rob #(
    parameter int unsigned DEPTH   = 8,
    parameter int unsigned DATA_W  = 16,
    parameter int unsigned AREG_W  = 3,
    localparam int unsigned TAG_W  = $clog2(DEPTH),
    localparam int unsigned CNT_W  = $clog2(DEPTH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              alloc_en,
    input  logic [AREG_W-1:0] alloc_areg,
    input  logic              alloc_wen,
    output logic [TAG_W-1:0]  alloc_tag,
    output logic              full,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    input  logic [TAG_W-1:0]  rd_tag   [2],
    output logic [DATA_W-1:0] rd_value [2],
    input  logic              commit_en,
    output logic              head_valid,
    output logic [TAG_W-1:0]  head_tag,
    output logic [AREG_W-1:0] head_areg,
    output logic              head_wen,
    output logic [DATA_W-1:0] head_value
);
    logic              done_q  [DEPTH];
    logic              wen_q   [DEPTH];
    logic [AREG_W-1:0] areg_q  [DEPTH];
    logic [DATA_W-1:0] value_q [DEPTH];
    logic [TAG_W-1:0]  head_q, tail_q;
    logic [CNT_W-1:0]  cnt_q;

    function automatic logic [TAG_W-1:0] ptr_inc(input logic [TAG_W-1:0] ptr);
        return (ptr == TAG_W'(DEPTH - 1)) ? '0 : ptr + 1'b1;
    endfunction

    // Advance head and tail and track occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            cnt_q  <= '0;
        end else begin
            if (alloc_en)  tail_q <= ptr_inc(tail_q);
            if (commit_en) head_q <= ptr_inc(head_q);
            cnt_q <= cnt_q + CNT_W'(alloc_en) - CNT_W'(commit_en);
        end
    end

    // Fill slot fields on allocation and results on writeback.
    always_ff @(posedge clk) begin
        for (int i = 0; i < DEPTH; i++) begin
            if (!rst_n) begin
                done_q[i]  <= 1'b0;
                wen_q[i]   <= 1'b0;
                areg_q[i]  <= '0;
                value_q[i] <= '0;
            end else if (alloc_en && tail_q == TAG_W'(i)) begin
                done_q[i] <= 1'b0;
                wen_q[i]  <= alloc_wen;
                areg_q[i] <= alloc_areg;
            end else if (wb_en && wb_tag == TAG_W'(i)) begin
                done_q[i]  <= 1'b1;
                value_q[i] <= wb_value;
            end
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_read
        // Read a stored result for a source.
        assign rd_value[p] = value_q[rd_tag[p]];
    end

    // Present allocation and head state.
    always_comb begin
        alloc_tag  = tail_q;
        full       = (cnt_q == CNT_W'(DEPTH));
        head_valid = (cnt_q != '0) && done_q[head_q];
        head_tag   = head_q;
        head_areg  = areg_q[head_q];
        head_wen   = wen_q[head_q];
        head_value = value_q[head_q];
    end
endmodule

// File: rtl/vr_arf.sv
// Architectural register file: one write port from retirement, two
// combinational read ports. All registers reset to zero.
module vr_arf #(
    parameter int unsigned NUM_AREG = 8,
    parameter int unsigned DATA_W   = 16,
    localparam int unsigned AREG_W  = $clog2(NUM_AREG)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [AREG_W-1:0] wr_areg,
    input  logic [DATA_W-1:0] wr_value,
    input  logic [AREG_W-1:0] rd_areg  [2],
    output logic [DATA_W-1:0] rd_value [2]
);
    logic [DATA_W-1:0] regs_q [NUM_AREG];

    // Write the retiring value.
    always_ff @(posedge clk) begin
        for (int i = 0; i < NUM_AREG; i++) begin
            if (!rst_n)
                regs_q[i] <= '0;
            else if (wr_en && wr_areg == AREG_W'(i))
                regs_q[i] <= wr_value;
        end
    end

    for (genvar p = 0; p < 2; p++) begin : g_read
        // Read one architectural register.
        assign rd_value[p] = regs_q[rd_areg[p]];
    end
endmodule

// File: rtl/vr_operand_sel.sv
// Operand capture for one source: picks the architectural value, a stored
// slot result, a same-cycle writeback, or reports the slot to wait on.
module vr_operand_sel
    import vr_pkg::*;
#(
    parameter int unsigned TAG_W  = 3,
    parameter int unsigned DATA_W = 16
) (
    input  logic              map_valid,
    input  logic              map_pend,
    input  logic [TAG_W-1:0]  map_tag,
    input  logic [DATA_W-1:0] slot_value,
    input  logic [DATA_W-1:0] arf_value,
    input  logic              wb_en,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    output logic              pend,
    output logic [TAG_W-1:0]  tag,
    output logic [DATA_W-1:0] value
);
    src_kind_e kind;

    // Classify where the operand comes from.
    always_comb begin
        if (!map_valid)                  kind = SRC_ARF;
        else if (!map_pend)              kind = SRC_SLOT;
        else if (wb_en && wb_tag == map_tag) kind = SRC_FWD;
        else                             kind = SRC_WAIT;
    end

    // Drive the captured operand.
    always_comb begin
        pend = (kind == SRC_WAIT);
        tag  = map_tag;
        unique case (kind)
            SRC_ARF:  value = arf_value;
            SRC_SLOT: value = slot_value;
            SRC_FWD:  value = wb_value;
            default:  value = '0;
        endcase
    end
endmodule

// File: rtl/vr_rename_top.sv
// Value-based rename top: allocates reorder buffer slots as tags, captures
// two source operands, accepts writebacks and retires the oldest finished
// slot each cycle. Assumes writebacks name allocated, unfinished slots.
module vr_rename_top
    import vr_pkg::*;
#(
    parameter int unsigned NUM_AREG  = VR_AREGS,
    parameter int unsigned DATA_W    = VR_DATA_W,
    parameter int unsigned ROB_DEPTH = VR_ROB_DEPTH,
    localparam int unsigned AREG_W   = $clog2(NUM_AREG),
    localparam int unsigned TAG_W    = $clog2(ROB_DEPTH)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dec_valid,
    output logic              dec_ready,
    input  logic [AREG_W-1:0] dec_rd,
    input  logic              dec_wen,
    input  logic [AREG_W-1:0] dec_rs0,
    input  logic [AREG_W-1:0] dec_rs1,
    output logic [TAG_W-1:0]  dec_tag,
    output logic              src0_pend,
    output logic [TAG_W-1:0]  src0_tag,
    output logic [DATA_W-1:0] src0_value,
    output logic              src1_pend,
    output logic [TAG_W-1:0]  src1_tag,
    output logic [DATA_W-1:0] src1_value,
    input  logic              wb_valid,
    input  logic [TAG_W-1:0]  wb_tag,
    input  logic [DATA_W-1:0] wb_value,
    output logic              cmt_valid,
    output logic [TAG_W-1:0]  cmt_tag,
    output logic [AREG_W-1:0] cmt_areg,
    output logic              cmt_wen,
    output logic [DATA_W-1:0] cmt_value
);
    logic              rob_full, dec_fire;
    logic [TAG_W-1:0]  alloc_tag;
    logic [AREG_W-1:0] src_areg  [2];
    logic              map_valid [2];
    logic              map_pend  [2];
    logic [TAG_W-1:0]  map_tag   [2];
    logic [DATA_W-1:0] slot_val  [2];
    logic [DATA_W-1:0] arf_val   [2];
    logic              op_pend   [2];
    logic [TAG_W-1:0]  op_tag    [2];
    logic [DATA_W-1:0] op_val    [2];

    // Accept decode when a slot is free.
    always_comb begin
        dec_fire    = dec_valid && !rob_full;
        dec_ready   = !rob_full;
        dec_tag     = alloc_tag;
        src_areg[0] = dec_rs0;
        src_areg[1] = dec_rs1;
    end

    vr_rename_table #(.NUM_AREG(NUM_AREG), .TAG_W(TAG_W)) u_rt (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (dec_fire && dec_wen),
        .alloc_areg (dec_rd),
        .alloc_tag  (alloc_tag),
        .wb_en      (wb_valid),
        .wb_tag     (wb_tag),
        .clr_en     (cmt_valid && cmt_wen),
        .clr_areg   (cmt_areg),
        .clr_tag    (cmt_tag),
        .rd_areg    (src_areg),
        .rd_valid   (map_valid),
        .rd_pend    (map_pend),
        .rd_tag     (map_tag)
    );

    vr_rob #(.DEPTH(ROB_DEPTH), .DATA_W(DATA_W), .AREG_W(AREG_W)) u_rob (
        .clk        (clk),
        .rst_n      (rst_n),
        .alloc_en   (dec_fire),
        .alloc_areg (dec_rd),
        .alloc_wen  (dec_wen),
        .alloc_tag  (alloc_tag),
        .full       (rob_full),
        .wb_en      (wb_valid),
        .wb_tag     (wb_tag),
        .wb_value   (wb_value),
        .rd_tag     (map_tag),
        .rd_value   (slot_val),
        .commit_en  (cmt_valid),
        .head_valid (cmt_valid),
        .head_tag   (cmt_tag),
        .head_areg  (cmt_areg),
        .head_wen   (cmt_wen),
        .head_value (cmt_value)
    );

    vr_arf #(.NUM_AREG(NUM_AREG), .DATA_W(DATA_W)) u_arf (
        .clk      (clk),
        .rst_n    (rst_n),
        .wr_en    (cmt_valid && cmt_wen),
        .wr_areg  (cmt_areg),
        .wr_value (cmt_value),
        .rd_areg  (src_areg),
        .rd_value (arf_val)
    );

    for (genvar p = 0; p < 2; p++) begin : g_src
        vr_operand_sel #(.TAG_W(TAG_W), .DATA_W(DATA_W)) u_sel (
            .map_valid  (map_valid[p]),
            .map_pend   (map_pend[p]),
            .map_tag    (map_tag[p]),
            .slot_value (slot_val[p]),
            .arf_value  (arf_val[p]),
            .wb_en      (wb_valid),
            .wb_tag     (wb_tag),
            .wb_value   (wb_value),
            .pend       (op_pend[p]),
            .tag        (op_tag[p]),
            .value      (op_val[p])
        );
    end

    // Route captured operands to the ports.
    always_comb begin
        src0_pend  = op_pend[0];
        src0_tag   = op_tag[0];
        src0_value = op_val[0];
        src1_pend  = op_pend[1];
        src1_tag   = op_tag[1];
        src1_value = op_val[1];
    end
endmodule

// File: rtl/vr_rename_checker.sv
// Checker: tracks allocation order and occupancy from the ports and checks
// them against the block's outputs. Bound to vr_rename_top below.
module vr_rename_checker #(
    parameter int unsigned ROB_DEPTH = 8,
    parameter int unsigned TAG_W     = 3,
    localparam int unsigned CNT_W    = $clog2(ROB_DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             dec_valid,
    input logic             dec_ready,
    input logic [TAG_W-1:0] dec_tag,
    input logic             src0_pend,
    input logic [TAG_W-1:0] src0_tag,
    input logic             src1_pend,
    input logic [TAG_W-1:0] src1_tag,
    input logic             wb_valid,
    input logic [TAG_W-1:0] wb_tag,
    input logic             cmt_valid,
    input logic [TAG_W-1:0] cmt_tag
);
    logic [TAG_W-1:0] exp_alloc, exp_head;
    logic [CNT_W-1:0] occ;
    logic             fire;

    function automatic logic [TAG_W-1:0] nxt(input logic [TAG_W-1:0] t);
        return (t == TAG_W'(ROB_DEPTH - 1)) ? '0 : t + 1'b1;
    endfunction

    assign fire = dec_valid && dec_ready;

    // Shadow the allocation order and occupancy.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            exp_alloc <= '0;
            exp_head  <= '0;
            occ       <= '0;
        end else begin
            if (fire)      exp_alloc <= nxt(exp_alloc);
            if (cmt_valid) exp_head  <= nxt(exp_head);
            occ <= occ + CNT_W'(fire) - CNT_W'(cmt_valid);
        end
    end

    AST_RESET_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(rst_n) |-> (dec_ready && !cmt_valid)); // R1
    AST_ALLOC_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        fire |-> dec_tag == exp_alloc); // R2
    AST_FULL_STALL: assert property (@(posedge clk) disable iff (!rst_n)
        dec_ready == (occ != CNT_W'(ROB_DEPTH))); // R3
    AST_FWD_SRC0: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && src0_pend) |-> wb_tag != src0_tag); // R7
    AST_FWD_SRC1: assert property (@(posedge clk) disable iff (!rst_n)
        (wb_valid && src1_pend) |-> wb_tag != src1_tag); // R7
    AST_RETIRE_ORDER: assert property (@(posedge clk) disable iff (!rst_n)
        cmt_valid |-> (cmt_tag == exp_head && occ != '0)); // R8
endmodule

bind vr_rename_top vr_rename_checker #(.ROB_DEPTH(ROB_DEPTH), .TAG_W(TAG_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .dec_valid (dec_valid),
    .dec_ready (dec_ready),
    .dec_tag   (dec_tag),
    .src0_pend (src0_pend),
    .src0_tag  (src0_tag),
    .src1_pend (src1_pend),
    .src1_tag  (src1_tag),
    .wb_valid  (wb_valid),
    .wb_tag    (wb_tag),
    .cmt_valid (cmt_valid),
    .cmt_tag   (cmt_tag)
);

// File: tb/vr_rename_top_tb.sv
`timescale 1ns/1ps
module vr_rename_top_tb;
    localparam int NA = 8;
    localparam int DW = 16;
    localparam int DEPTH = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic dec_valid = 1'b0, dec_wen = 1'b0;
    logic [2:0] dec_rd = '0, dec_rs0 = '0, dec_rs1 = '0;
    logic dec_ready;
    logic [2:0] dec_tag;
    logic src0_pend, src1_pend;
    logic [2:0] src0_tag, src1_tag;
    logic [DW-1:0] src0_value, src1_value;
    logic wb_valid = 1'b0;
    logic [2:0] wb_tag = '0;
    logic [DW-1:0] wb_value = '0;
    logic cmt_valid, cmt_wen;
    logic [2:0] cmt_tag, cmt_areg;
    logic [DW-1:0] cmt_value;

    always #2.5 clk = ~clk;

    vr_rename_top u_dut (
        .clk(clk), .rst_n(rst_n),
        .dec_valid(dec_valid), .dec_ready(dec_ready), .dec_rd(dec_rd), .dec_wen(dec_wen),
        .dec_rs0(dec_rs0), .dec_rs1(dec_rs1), .dec_tag(dec_tag),
        .src0_pend(src0_pend), .src0_tag(src0_tag), .src0_value(src0_value),
        .src1_pend(src1_pend), .src1_tag(src1_tag), .src1_value(src1_value),
        .wb_valid(wb_valid), .wb_tag(wb_tag), .wb_value(wb_value),
        .cmt_valid(cmt_valid), .cmt_tag(cmt_tag), .cmt_areg(cmt_areg),
        .cmt_wen(cmt_wen), .cmt_value(cmt_value)
    );

    int n_cmp = 0, n_bad = 0;
    bit finished = 0;

    // reference model state
    int m_arf [NA];
    bit m_rtv [NA];
    int m_rtt [NA];
    bit m_done [DEPTH];
    bit m_wen [DEPTH];
    int m_areg [DEPTH];
    int m_val [DEPTH];
    int m_head = 0, m_tail = 0, m_cnt = 0;

    task automatic check(input string req, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s: got %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic chk_src(input int rs, input bit pend, input int tag, input int val,
                           input string lbl, input string nm);
        string req;
        bit epend;
        int eval, t;
        epend = 0; eval = 0; t = m_rtt[rs];
        if (!m_rtv[rs]) begin req = "R6"; eval = m_arf[rs]; end
        else if (m_done[t]) begin req = "R5"; eval = m_val[t]; end
        else if (wb_valid && int'(wb_tag) == t) begin req = "R7"; eval = int'(wb_value); end
        else begin req = "R4"; epend = 1; end
        if (lbl != "") req = lbl;
        check(req, {nm, " pend"}, int'(pend), int'(epend));
        if (epend) check(req, {nm, " tag"}, tag, t);
        else       check(req, {nm, " value"}, val, eval);
    endtask

    // One cycle: drive, check combinational outputs against the model, advance the model.
    task automatic cycle(input bit dv, input int rd, input bit wen, input int rs0, input int rs1,
                         input bit wv, input int wt, input int wval, input string lbl);
        bit fire, cmt;
        int h;
        @(negedge clk);
        dec_valid = dv; dec_rd = 3'(rd); dec_wen = wen;
        dec_rs0 = 3'(rs0); dec_rs1 = 3'(rs1);
        wb_valid = wv; wb_tag = 3'(wt); wb_value = DW'(wval);
        #1;
        check("R3", "dec_ready", int'(dec_ready), int'(m_cnt < DEPTH));
        if (m_cnt < DEPTH) check("R2", "dec_tag", int'(dec_tag), m_tail);
        chk_src(rs0, src0_pend, int'(src0_tag), int'(src0_value), lbl, "src0");
        chk_src(rs1, src1_pend, int'(src1_tag), int'(src1_value), lbl, "src1");
        h = m_head;
        cmt = (m_cnt > 0) && m_done[h];
        check("R8", "cmt_valid", int'(cmt_valid), int'(cmt));
        if (cmt) begin
            check("R8", "cmt_tag", int'(cmt_tag), h);
            check("R8", "cmt_areg", int'(cmt_areg), m_areg[h]);
            check("R8", "cmt_wen", int'(cmt_wen), int'(m_wen[h]));
            check("R8", "cmt_value", int'(cmt_value), m_val[h]);
        end
        fire = dv && (m_cnt < DEPTH);
        if (cmt) begin
            if (m_wen[h]) begin
                m_arf[m_areg[h]] = m_val[h];
                if (m_rtv[m_areg[h]] && m_rtt[m_areg[h]] == h) m_rtv[m_areg[h]] = 0;
            end
            m_head = (m_head + 1) % DEPTH;
        end
        if (wv) begin m_val[wt] = wval & 16'hFFFF; m_done[wt] = 1; end
        if (fire) begin
            m_wen[m_tail] = wen; m_areg[m_tail] = rd; m_done[m_tail] = 0;
            if (wen) begin m_rtv[rd] = 1; m_rtt[rd] = m_tail; end
            m_tail = (m_tail + 1) % DEPTH;
        end
        m_cnt = m_cnt + int'(fire) - int'(cmt);
    endtask

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            n_cmp++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd4242));
        for (int i = 0; i < NA; i++) begin m_arf[i] = 0; m_rtv[i] = 0; m_rtt[i] = 0; end
        for (int i = 0; i < DEPTH; i++) begin m_done[i] = 0; m_wen[i] = 0; m_areg[i] = 0; m_val[i] = 0; end
        repeat (3) @(posedge clk);
        @(negedge clk) rst_n = 1'b1;
        #1;
        check("R1", "dec_ready", int'(dec_ready), 1);
        check("R1", "cmt_valid", int'(cmt_valid), 0);
        cycle(0, 0, 0, 2, 6, 0, 0, 0, "R1");

        // R10: two writers of x3, older one retires, younger mapping survives
        cycle(1, 3, 1, 0, 0, 0, 0, 0, "");          // slot 0
        cycle(1, 3, 1, 0, 0, 0, 0, 0, "");          // slot 1
        cycle(0, 0, 0, 0, 0, 1, 0, 'h111, "");      // result of slot 0
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "");          // slot 0 retires
        cycle(0, 0, 0, 3, 3, 0, 0, 0, "R10");       // x3 still waits on slot 1
        // R9: retirement writes the file
        cycle(0, 0, 0, 0, 0, 1, 1, 'h222, "");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "");          // slot 1 retires
        cycle(0, 0, 0, 3, 1, 0, 0, 0, "R9");        // x3 = 0x222 from file
        // R9: slot without destination leaves x3 alone
        cycle(1, 3, 0, 0, 0, 0, 0, 0, "");          // slot 2, no write
        cycle(0, 0, 0, 0, 0, 1, 2, 'h333, "");
        cycle(0, 0, 0, 0, 0, 0, 0, 0, "");
        cycle(0, 0, 0, 3, 3, 0, 0, 0, "R9");
        // R11: new writer of x5 accepted while old writer retires
        cycle(1, 5, 1, 0, 0, 0, 0, 0, "");          // slot 3
        cycle(0, 0, 0, 0, 0, 1, 3, 'h444, "");
        cycle(1, 5, 1, 0, 0, 0, 0, 0, "");          // slot 4 alongside retirement of 3
        cycle(0, 0, 0, 5, 5, 0, 0, 0, "R11");
        // R7: same-cycle writeback is captured as a value
        cycle(0, 0, 0, 5, 2, 1, 4, 'h555, "R7");
        repeat (3) cycle(0, 0, 0, 0, 0, 0, 0, 0, "");
        // R3: fill every slot without results, then press on while full
        for (int i = 0; i < DEPTH + 3; i++) cycle(1, i % NA, 1, (i + 1) % NA, i % NA, 0, 0, 0, "");

        // constrained random traffic
        for (int n = 0; n < 4000; n++) begin
            bit dv, wen, wv;
            int rd, rs0, rs1, wt, wval, off;
            dv = ($urandom % 3) != 0;
            wen = ($urandom % 5) != 0;
            rd = $urandom % NA;
            rs0 = $urandom % NA;
            rs1 = $urandom % NA;
            wval = $urandom % 65536;
            wv = 0; wt = 0;
            if (m_cnt > 0) begin
                off = $urandom % m_cnt;
                wt = (m_head + off) % DEPTH;
                wv = !m_done[wt] && (($urandom % 4) != 0);
                if (m_rtv[rs0] && !m_done[m_rtt[rs0]] && ($urandom % 3) == 0) begin
                    wt = m_rtt[rs0]; wv = 1;
                end
            end
            cycle(dv, rd, wen, rs0, rs1, wv, wt, wval, "");
        end
        finished = 1;
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule